// File: doc/BRIEF.md
# Cascadable Serial Configuration Bit Reader

This block is the read path of a one-bit-wide configuration store that feeds a programmable logic device loading itself in master serial mode. The loading device supplies the configuration clock. On every rising edge while the reader is selected, an internal bit pointer moves forward by one position, and the stored bit at the pointer is offered on a data output. The data output is qualified by a separate drive-enable, so that several readers can share one data line.

The reader has three control inputs. An active-low chip select selects it. A combined reset/output-enable input has its reset level fixed by the `RST_POL` parameter. A serial-enable input must be high for read mode. When the last stored bit has been delivered, the reader stops driving and pulls its active-low chain output low. That output drives the chip select of the next reader, so a chain of readers delivers one unbroken bitstream. The bit image is written before reading through a simple load port.

Top module: `cfg_serial_reader`

## Requirements
- R1: After power-on reset, the pointer is at bit 0 and the reader does not drive. With serial-enable high and chip select high, `dout_oe_o` is 0 and `ceo_n_o` is 1.
- R2: `dout_oe_o` is 1 only when all of the following hold: serial-enable is high, `ce_n_i` is low, the reset level is not applied, and the final bit has not yet been passed. In every other case it is 0.
- R3: On each rising clock edge while the reader is driving, the pointer moves forward by exactly one bit. `dout_o` then presents `image[pointer]`.
- R4: A clock edge that sees the reset level with serial-enable high puts the pointer back to bit 0 and clears the end-of-image state. This happens even while `ce_n_i` is high.
- R5: While `ce_n_i` is high, the pointer does not move and `dout_oe_o` is 0. When the reader is selected again, reading continues from the bit where it stopped.
- R6: The edge that passes bit DEPTH-1 drops `dout_oe_o` and drives `ceo_n_o` low. After that the pointer does not wrap, and the reader stays silent until it is reset.
- R7: Once the end of the image is reached, `ceo_n_o` equals `ce_n_i` while the reset level is absent. It goes high as soon as the reset level is applied, and it stays high after the reset until the whole image has been read again.
- R8: With `RST_POL`=1, a high level on `rst_oe_i` is the reset level. With `RST_POL`=0, a low level is the reset level. The other level enables the output.
- R9: While `ser_en_i` is low, the reader does not drive, `ceo_n_o` is 1, and both chip select and reset have no effect on the pointer.
- R10: In a chain of two readers, with the first reader's `ceo_n_o` driving the second reader's `ce_n_i`, the shared line carries image A bits 0..DEPTH-1 followed at once by image B bits 0..DEPTH-1, one bit per clock. The two readers never drive at the same time.
- R11: A load-port write with `ld_we_i`=1 stores `ld_bit_i` at address `ld_addr_i` on the rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Configuration clock from the loading device |
| por_n_i | input | 1 | Power-on reset, active low |
| ser_en_i | input | 1 | Serial-enable; high selects read mode |
| ce_n_i | input | 1 | Chip select, active low |
| rst_oe_i | input | 1 | Combined reset/output-enable; reset level set by RST_POL |
| ld_we_i | input | 1 | Image load write strobe |
| ld_addr_i | input | AW | Image load bit address |
| ld_bit_i | input | 1 | Image load bit value |
| dout_o | output | 1 | Bit at the current pointer |
| dout_oe_o | output | 1 | Drive-enable for the shared data line |
| ceo_n_o | output | 1 | Chain output to the next reader's chip select, active low |

## Verification
The assertions check on every clock that the pointer holds in standby and steps by one while reading. They also check that a reset edge returns the pointer to zero, that the end-of-image state never clears without a reset, and that the drive-enable and the chain output are never both active. A third group covers serial-enable low and chip select high: in those states the reader must be silent. Only the bench scenarios can show that the delivered bits match the loaded image, that the handoff between two chained readers leaves no gap and no repeated bit, and that reading resumes at the correct bit after standby or after serial-enable has been low. The bench scenarios also show how the chain output follows chip select after the end, with both reset polarities.

// File: rtl/cfgrd_pkg.sv
package cfgrd_pkg;
   function automatic int unsigned ptr_width(input int unsigned depth);
      return (depth < 2) ? 1 : $clog2(depth);
   endfunction
endpackage

// File: rtl/cfgrd_pol.sv
module cfgrd_pol #(
   parameter int RST_POL = 1
) (
   input  logic raw_i,
   output logic rst_hit_o
);
   generate
      if (RST_POL == 1) begin : g_high
         assign rst_hit_o = raw_i;
      end else begin : g_low
         assign rst_hit_o = ~raw_i;
      end
   endgenerate
endmodule

// File: rtl/cfgrd_store.sv
module cfgrd_store #(
   parameter int DEPTH = 1024,
   parameter int AW    = 10
) (
   input  logic          clk_i,
   input  logic          we_i,
   input  logic [AW-1:0] waddr_i,
   input  logic          wbit_i,
   input  logic [AW-1:0] raddr_i,
   output logic          rbit_o
);
   logic bits_q [DEPTH];

   always_ff @(posedge clk_i) begin
      if (we_i) bits_q[waddr_i] <= wbit_i;
   end

   assign rbit_o = bits_q[raddr_i];
endmodule

// File: rtl/cfgrd_ptr.sv
module cfgrd_ptr #(
   parameter int DEPTH = 1024,
   parameter int AW    = 10
) (
   input  logic          clk_i,
   input  logic          por_n_i,
   input  logic          ser_en_i,
   input  logic          ce_n_i,
   input  logic          rst_hit_i,
   output logic [AW-1:0] ptr_o,
   output logic          end_o
);
   localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

   logic [AW-1:0] ptr_q;
   logic          end_q;
   logic          clear, run;

   assign clear = ser_en_i & rst_hit_i;
   assign run   = ser_en_i & ~ce_n_i & ~rst_hit_i & ~end_q;

   always_ff @(posedge clk_i or negedge por_n_i) begin
      if (!por_n_i) begin
         ptr_q <= '0;
         end_q <= 1'b0;
      end else if (clear) begin
         ptr_q <= '0;
         end_q <= 1'b0;
      end else if (run) begin
         if (ptr_q == LAST) end_q <= 1'b1;
         else               ptr_q <= ptr_q + AW'(1);
      end
   end

   assign ptr_o = ptr_q;
   assign end_o = end_q;

   assert_hold_standby_R5: assert property (@(posedge clk_i) disable iff (!por_n_i)
      (ser_en_i && ce_n_i && !rst_hit_i) |=> $stable(ptr_q));
   assert_hold_serial_off_R9: assert property (@(posedge clk_i) disable iff (!por_n_i)
      (!ser_en_i) |=> ($stable(ptr_q) && $stable(end_q)));
   assert_clear_R4: assert property (@(posedge clk_i) disable iff (!por_n_i)
      (ser_en_i && rst_hit_i) |=> (ptr_q == '0 && !end_q));
   assert_step_R3: assert property (@(posedge clk_i) disable iff (!por_n_i)
      (ser_en_i && !ce_n_i && !rst_hit_i && !end_q && ptr_q != LAST)
      |=> (ptr_q == $past(ptr_q) + AW'(1)));
   assert_no_wrap_R6: assert property (@(posedge clk_i) disable iff (!por_n_i)
      (end_q && !(ser_en_i && rst_hit_i)) |=> (end_q && ptr_q == LAST));
endmodule

// File: rtl/cfg_serial_reader.sv
module cfg_serial_reader
   import cfgrd_pkg::*;
#(
   parameter int DEPTH   = 1024,
   parameter int RST_POL = 1,
   parameter int AW      = ptr_width(DEPTH)
) (
   input  logic          clk_i,
   input  logic          por_n_i,
   input  logic          ser_en_i,
   input  logic          ce_n_i,
   input  logic          rst_oe_i,
   input  logic          ld_we_i,
   input  logic [AW-1:0] ld_addr_i,
   input  logic          ld_bit_i,
   output logic          dout_o,
   output logic          dout_oe_o,
   output logic          ceo_n_o
);
   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("cfg_serial_reader: DEPTH must be at least 2");
      end
      if (RST_POL != 0 && RST_POL != 1) begin : g_bad_pol
         $error("cfg_serial_reader: RST_POL must be 0 or 1");
      end
      if ((1 << AW) < DEPTH) begin : g_bad_aw
         $error("cfg_serial_reader: AW too narrow for DEPTH");
      end
   endgenerate

   logic          rst_hit;
   logic [AW-1:0] ptr;
   logic          at_end;
   logic          cur_bit;

   cfgrd_pol #(.RST_POL(RST_POL)) u_pol (
      .raw_i     (rst_oe_i),
      .rst_hit_o (rst_hit)
   );

   cfgrd_ptr #(.DEPTH(DEPTH), .AW(AW)) u_ptr (
      .clk_i     (clk_i),
      .por_n_i   (por_n_i),
      .ser_en_i  (ser_en_i),
      .ce_n_i    (ce_n_i),
      .rst_hit_i (rst_hit),
      .ptr_o     (ptr),
      .end_o     (at_end)
   );

   cfgrd_store #(.DEPTH(DEPTH), .AW(AW)) u_store (
      .clk_i   (clk_i),
      .we_i    (ld_we_i),
      .waddr_i (ld_addr_i),
      .wbit_i  (ld_bit_i),
      .raddr_i (ptr),
      .rbit_o  (cur_bit)
   );

   logic selected;
   assign selected  = ser_en_i & ~ce_n_i & ~rst_hit;
   assign dout_oe_o = selected & ~at_end;
   assign ceo_n_o   = ~(selected & at_end);
   assign dout_o    = cur_bit;

   assert_handoff_exclusive_R6: assert property (@(posedge clk_i) disable iff (!por_n_i)
      !(dout_oe_o && !ceo_n_o));
   assert_serial_off_silent_R9: assert property (@(posedge clk_i) disable iff (!por_n_i)
      (!ser_en_i) |-> (!dout_oe_o && ceo_n_o));
   assert_standby_silent_R5: assert property (@(posedge clk_i) disable iff (!por_n_i)
      ce_n_i |-> (!dout_oe_o && ceo_n_o));
   assert_end_drops_drive_R6: assert property (@(posedge clk_i) disable iff (!por_n_i)
      ($fell(dout_oe_o) && $stable(ce_n_i) && $stable(rst_oe_i) && $stable(ser_en_i)
       && ser_en_i && !ce_n_i) |-> !ceo_n_o);
endmodule

// File: tb/sim_cfg_serial_reader.sv
module sim_cfg_serial_reader;
   localparam int CLK_PERIOD = 10;
   localparam int DEPTH = 16;
   localparam int AW = 4;

   logic clk = 1'b0;
   always #(CLK_PERIOD / 2) clk = ~clk;

   logic por_n = 1'b0, ser_en = 1'b0, ce_n = 1'b1, rst_l = 1'b0;
   logic ld_we0 = 1'b0, ld_we1 = 1'b0, ld_bit = 1'b0;
   logic [AW-1:0] ld_addr = '0;
   logic d0, oe0, ceo0_n, d1, oe1, ceo1_n;

   // R8: first reader resets on a high level, second on a low level
   cfg_serial_reader #(.DEPTH(DEPTH), .RST_POL(1)) u0 (
      .clk_i(clk), .por_n_i(por_n), .ser_en_i(ser_en), .ce_n_i(ce_n),
      .rst_oe_i(rst_l), .ld_we_i(ld_we0), .ld_addr_i(ld_addr), .ld_bit_i(ld_bit),
      .dout_o(d0), .dout_oe_o(oe0), .ceo_n_o(ceo0_n));
   cfg_serial_reader #(.DEPTH(DEPTH), .RST_POL(0)) u1 (
      .clk_i(clk), .por_n_i(por_n), .ser_en_i(ser_en), .ce_n_i(ceo0_n),
      .rst_oe_i(~rst_l), .ld_we_i(ld_we1), .ld_addr_i(ld_addr), .ld_bit_i(ld_bit),
      .dout_o(d1), .dout_oe_o(oe1), .ceo_n_o(ceo1_n));

   logic bus_oe, bus_d;
   assign bus_oe = oe0 | oe1;
   assign bus_d  = oe0 ? d0 : d1;

   int checks = 0, errors = 0;
   bit exp_q[$];
   bit mon_on = 1'b0;
   string mon_tag = "R3";

   function automatic bit img0(int i);
      return ((i * 5 + 3) % 7) < 3;
   endfunction
   function automatic bit img1(int i);
      return i[0] ^ i[2] ^ i[3];
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic run_q(input string tag);
      mon_tag = tag;
      mon_on = 1'b1;
      wait (exp_q.size() == 0);
      mon_on = 1'b0;
   endtask

   // monitor: compares the shared line against the scoreboard queue
   always @(negedge clk) begin
      if (oe0 && oe1) chk(1'b0, "R10 contention", 2, 1);
      if (mon_on && exp_q.size() > 0) begin
         bit e;
         e = exp_q.pop_front();
         chk(bus_oe && (bus_d == e), mon_tag, {30'd0, bus_oe, bus_d}, {30'd0, 1'b1, e});
      end
   end

   bit finished = 1'b0;
   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   initial begin
      #(CLK_PERIOD * 20000);
      chk(1'b0, "watchdog", 0, 1);
      finish_run();
   end

   initial begin
      repeat (3) tick();
      por_n = 1'b1;
      tick();
      // R11: load both images through the load port
      for (int i = 0; i < DEPTH; i++) begin
         ld_we0 = 1'b1; ld_we1 = 1'b1; ld_addr = AW'(i); ld_bit = img0(i);
         tick();
         ld_we0 = 1'b1; ld_we1 = 1'b1; ld_bit = img1(i);
         ld_we0 = 1'b0;
         tick();
      end
      ld_we0 = 1'b0; ld_we1 = 1'b0;
      // reload first image cleanly (second-phase write above only hit u1)
      for (int i = 0; i < DEPTH; i++) begin
         ld_we0 = 1'b1; ld_addr = AW'(i); ld_bit = img0(i);
         tick();
      end
      ld_we0 = 1'b0;
      tick();

      // R1: reset state with serial-enable high, chip select high
      ser_en = 1'b1;
      @(negedge clk);
      chk(oe0 == 1'b0, "R1 oe", oe0, 0);
      chk(ceo0_n == 1'b1, "R1 ceo", ceo0_n, 1);
      tick();

      // R10/R3/R11/R8: continuous stream across the chain
      ce_n = 1'b0;
      for (int i = 0; i < DEPTH; i++) exp_q.push_back(img0(i));
      for (int i = 0; i < DEPTH; i++) exp_q.push_back(img1(i));
      run_q("R10");

      // R6: end of chain, no driving, no wrap
      tick();
      @(negedge clk);
      chk(bus_oe == 1'b0, "R6 oe after last", bus_oe, 0);
      chk(ceo0_n == 1'b0, "R6 ceo0 low", ceo0_n, 0);
      chk(ceo1_n == 1'b0, "R6 ceo1 low", ceo1_n, 0);
      repeat (3) tick();
      @(negedge clk);
      chk(bus_oe == 1'b0, "R6 no wrap", bus_oe, 0);

      // R7: chain output follows chip select after the end
      tick();
      ce_n = 1'b1;
      @(negedge clk);
      chk(ceo0_n == 1'b1, "R7 follows ce high", ceo0_n, 1);
      chk(ceo1_n == 1'b1, "R7 downstream follows", ceo1_n, 1);
      tick();
      ce_n = 1'b0;
      @(negedge clk);
      chk(ceo0_n == 1'b0, "R7 follows ce low", ceo0_n, 0);
      tick();
      rst_l = 1'b1;
      @(negedge clk);
      chk(ceo0_n == 1'b1, "R7 high on reset", ceo0_n, 1);
      chk(ceo1_n == 1'b1, "R8 low-polarity reader high on reset", ceo1_n, 1);
      chk(bus_oe == 1'b0, "R2 silent in reset", bus_oe, 0);
      tick();
      rst_l = 1'b0;
      @(negedge clk);
      chk(ceo0_n == 1'b1, "R7 stays high after reset", ceo0_n, 1);
      @(posedge clk);
      #1;
      // here the posedge already advanced to bit 1; restart cleanly
      rst_l = 1'b1;
      tick();
      rst_l = 1'b0;

      // R4: restart from bit 0
      for (int i = 0; i < 3; i++) exp_q.push_back(img0(i));
      run_q("R4");
      ce_n = 1'b1;

      // R5: standby freezes pointer
      repeat (3) tick();
      @(negedge clk);
      chk(oe0 == 1'b0, "R5 standby silent", oe0, 0);
      tick();
      ce_n = 1'b0;
      exp_q.push_back(img0(2));
      exp_q.push_back(img0(3));
      run_q("R5");
      ce_n = 1'b1;

      // R4: reset applied while chip select is high
      tick();
      rst_l = 1'b1;
      tick();
      rst_l = 1'b0;
      ce_n = 1'b0;
      exp_q.push_back(img0(0));
      exp_q.push_back(img0(1));
      run_q("R4 ce high");
      ser_en = 1'b0;

      // R9: serial-enable low ignores chip select and reset
      tick();
      @(negedge clk);
      chk(oe0 == 1'b0, "R9 silent", oe0, 0);
      chk(ceo0_n == 1'b1, "R9 ceo high", ceo0_n, 1);
      tick();
      ce_n = 1'b1;
      rst_l = 1'b1;
      tick();
      ce_n = 1'b0;
      tick();
      rst_l = 1'b0;
      ser_en = 1'b1;
      exp_q.push_back(img0(1));
      exp_q.push_back(img0(2));
      run_q("R9 resume");

      tick();
      finish_run();
   end
endmodule